// File: doc/BRIEF.md
# Stepped Stereo Volume Stage with Mute and Silence Detection

This block applies one shared gain setting to a stream of stereo 20-bit signed PCM samples. The gain is picked from 128 steps of 0.75 dB each. The highest step gives +12 dB and the lowest gives -83.25 dB. Each step maps to a constant Q4.12 multiplier. Every product is rounded, then clipped to the 20-bit signed range. Each channel can be muted on its own, and a muted channel sends out zeros.

Each channel also watches its own input for silence. The silence flag rises once a chosen number of back-to-back zero samples has arrived, and that number is set in sample periods. The gain code, the two mute bits and the silence timeout are taken from the input pins only when the write strobe `cfg_wr` is pulsed. An active-low reset puts back the defaults: 0 dB, both channels unmuted, and the shortest timeout.

Top module: `vol_stage`

## Requirements
- R1: While `rst_n` is low, `out_valid`, both outputs and both silence flags are 0. After reset the stored gain code is 10H (0 dB), both mutes are off and the timeout select is 0.
- R2: Gain code 10H passes each unmuted sample through with no change at all.
- R3: Gain code c applies a gain of 12 − 0.75·c dB, using a 16-bit Q4.12 multiplier rounded to nearest. The result is the rounded product, and it lies within |x|/8192 + 1 of the ideal value.
- R4: A scaled result above 524287 comes out as 524287. A scaled result below −524288 comes out as −524288.
- R5: Outputs change one clock after an `in_valid` cycle, and `out_valid` is high for exactly that one cycle. With no strobe, the outputs hold their values.
- R6: `mute_left` and `mute_right` force only their own channel's output to 0. The other channel keeps scaling.
- R7: A channel's silence flag goes high on the N-th consecutive zero input sample, where N is 513, 1025, 2049 or 4097 for stored timeout select 0, 1, 2 or 3. The flag updates in the same cycle as the output. Channels are counted separately, and the mute bits have no effect on the count.
- R8: A non-zero input sample clears that channel's flag and restarts its count from zero.
- R9: The gain code, mute and timeout-select pins take effect only through a `cfg_wr` pulse. Changes on those pins with no pulse have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, restores the defaults |
| cfg_wr | input | 1 | Strobe that loads gain, mutes and timeout select |
| gain_code | input | 7 | Gain step, 0 = +12 dB, 0.75 dB lower per step |
| mute_left | input | 1 | Left mute value loaded on `cfg_wr` |
| mute_right | input | 1 | Right mute value loaded on `cfg_wr` |
| zto_sel | input | 2 | Silence timeout select loaded on `cfg_wr` |
| in_valid | input | 1 | Input sample strobe |
| in_left | input | 20 | Left input sample, two's complement |
| in_right | input | 20 | Right input sample, two's complement |
| out_valid | output | 1 | Output sample strobe |
| out_left | output | 20 | Scaled left sample |
| out_right | output | 20 | Scaled right sample |
| zero_left | output | 1 | Left silence flag |
| zero_right | output | 1 | Right silence flag |

## Verification
Unity gain is tested with mixed-sign values, including both extremes. This shows whether a sample passes through the datapath exactly, or picks up a rounding or sign-extension fault.

Positive, negative and cut codes are compared against an ideal real-valued gain. This separates a table indexed wrongly, or stepped wrongly, from a small quantisation error. Full-scale samples at boost codes drive the result past both rails, which tests clipping on each side.

Runs of zeros that stop one sample short of the timeout, and runs that reach it exactly, show whether the silence count is off by one. A non-zero sample in the middle of a run, and runs under different timeout selects, show whether the count restarts and whether the select is decoded correctly.

// File: rtl/vol_pkg.sv
package vol_pkg;
  localparam int SAMPLE_W = 20;
  localparam int MULT_W   = 16;
  localparam int FRAC_W   = 12;
  localparam int PROD_W   = SAMPLE_W + MULT_W + 1;
  localparam real TOP_DB  = 12.0;
  localparam real STEP_DB = 0.75;

  // Q4.12 multiplier for one gain step, evaluated at elaboration only
  function automatic logic [MULT_W-1:0] step_mult(input int code);
    real lin;
    lin = 10.0 ** ((TOP_DB - STEP_DB * real'(code)) / 20.0);
    return MULT_W'($rtoi(lin * real'(1 << FRAC_W) + 0.5));
  endfunction

  // multiply, round half up, clip to the sample range
  function automatic logic signed [SAMPLE_W-1:0] scale_round_sat(
      input logic signed [SAMPLE_W-1:0] x,
      input logic [MULT_W-1:0] m);
    logic signed [PROD_W-1:0] prod, half, sh, maxv, minv;
    prod = PROD_W'($signed(x) * $signed({1'b0, m}));
    half = PROD_W'(1) <<< (FRAC_W - 1);
    sh   = (prod + half) >>> FRAC_W;
    maxv = PROD_W'((1 << (SAMPLE_W - 1)) - 1);
    minv = -maxv - PROD_W'(1);
    if (sh > maxv)      sh = maxv;
    else if (sh < minv) sh = minv;
    return sh[SAMPLE_W-1:0];
  endfunction
endpackage

// File: rtl/vol_gain_rom.sv
module vol_gain_rom #(
  parameter int CODE_W = 7
) (
  input  logic [CODE_W-1:0]          code,
  output logic [vol_pkg::MULT_W-1:0] mult
);
  localparam int DEPTH = 1 << CODE_W;

  logic [vol_pkg::MULT_W-1:0] tbl [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_step
    assign tbl[i] = vol_pkg::step_mult(i);
  end

  assign mult = tbl[code];
endmodule

// File: rtl/vol_scale_ch.sv
module vol_scale_ch (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                in_valid,
  input  logic signed [vol_pkg::SAMPLE_W-1:0] sample,
  input  logic [vol_pkg::MULT_W-1:0]          mult,
  input  logic                                mute,
  output logic signed [vol_pkg::SAMPLE_W-1:0] result
);
  logic signed [vol_pkg::SAMPLE_W-1:0] scaled;

  assign scaled = mute ? '0 : vol_pkg::scale_round_sat(sample, mult);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        result <= '0;
    else if (in_valid) result <= scaled;
  end
endmodule

// File: rtl/vol_zero_det.sv
module vol_zero_det #(
  parameter int SAMPLE_W = 20,
  parameter int SEL_W    = 2,
  parameter int ZTO_BASE = 512
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [SEL_W-1:0]    sel,
  output logic                flag
);
  localparam int MAX_LIM = (ZTO_BASE << ((1 << SEL_W) - 1)) + 1;
  localparam int CNT_W   = $clog2(MAX_LIM + 1);

  logic [CNT_W-1:0] cnt, cnt_inc, limit;

  assign limit   = (CNT_W'(ZTO_BASE) << sel) + CNT_W'(1);
  assign cnt_inc = (cnt >= limit) ? cnt : cnt + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else if (in_valid) begin
      if (sample == '0) begin
        cnt  <= cnt_inc;
        flag <= (cnt_inc >= limit);
      end else begin
        cnt  <= '0;
        flag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vol_stage.sv
module vol_stage #(
  parameter int CODE_W     = 7,
  parameter int SEL_W      = 2,
  parameter int ZTO_BASE   = 512,
  parameter int UNITY_CODE = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_wr,
  input  logic [CODE_W-1:0]       gain_code,
  input  logic                    mute_left,
  input  logic                    mute_right,
  input  logic [SEL_W-1:0]        zto_sel,
  input  logic                    in_valid,
  input  logic signed [19:0]      in_left,
  input  logic signed [19:0]      in_right,
  output logic                    out_valid,
  output logic signed [19:0]      out_left,
  output logic signed [19:0]      out_right,
  output logic                    zero_left,
  output logic                    zero_right
);
  localparam int SW   = vol_pkg::SAMPLE_W;
  localparam int NCH  = 2;

  // stored settings, brought out by name for the checker
  logic [CODE_W-1:0]          gain_q;
  logic                       mute_l_q, mute_r_q;
  logic [SEL_W-1:0]           zto_q;
  logic [vol_pkg::MULT_W-1:0] mult;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q   <= CODE_W'(UNITY_CODE);
      mute_l_q <= 1'b0;
      mute_r_q <= 1'b0;
      zto_q    <= '0;
    end else if (cfg_wr) begin
      gain_q   <= gain_code;
      mute_l_q <= mute_left;
      mute_r_q <= mute_right;
      zto_q    <= zto_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  vol_gain_rom #(.CODE_W(CODE_W)) u_rom (.code(gain_q), .mult(mult));

  logic signed [SW-1:0] ch_in  [NCH];
  logic signed [SW-1:0] ch_out [NCH];
  logic                 ch_mute[NCH];
  logic                 ch_zero[NCH];

  assign ch_in[0]   = in_left;
  assign ch_in[1]   = in_right;
  assign ch_mute[0] = mute_l_q;
  assign ch_mute[1] = mute_r_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    vol_scale_ch u_scale (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .sample(ch_in[c]), .mult(mult), .mute(ch_mute[c]),
      .result(ch_out[c])
    );
    vol_zero_det #(.SAMPLE_W(SW), .SEL_W(SEL_W), .ZTO_BASE(ZTO_BASE)) u_zdet (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .sample(ch_in[c]), .sel(zto_q), .flag(ch_zero[c])
    );
  end

  assign out_left   = ch_out[0];
  assign out_right  = ch_out[1];
  assign zero_left  = ch_zero[0];
  assign zero_right = ch_zero[1];
endmodule

// File: rtl/vol_stage_chk.sv
module vol_stage_chk #(
  parameter int CODE_W     = 7,
  parameter int UNITY_CODE = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_wr,
  input logic               in_valid,
  input logic signed [19:0] in_left,
  input logic signed [19:0] in_right,
  input logic               out_valid,
  input logic signed [19:0] out_left,
  input logic signed [19:0] out_right,
  input logic               zero_left,
  input logic               zero_right,
  input logic [CODE_W-1:0]  gain_q,
  input logic               mute_l_q,
  input logic               mute_r_q
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R5
  AST_VALID_CAUSED: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> $past(in_valid)); // R5
  AST_HOLD_LEFT: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(out_left)); // R5
  AST_HOLD_RIGHT: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(out_right)); // R5
  AST_UNITY_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(gain_q) == CODE_W'(UNITY_CODE) && !$past(mute_l_q)) |-> out_left == $past(in_left)); // R2
  AST_UNITY_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(gain_q) == CODE_W'(UNITY_CODE) && !$past(mute_r_q)) |-> out_right == $past(in_right)); // R2
  AST_MUTE_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(mute_l_q)) |-> out_left == '0); // R6
  AST_MUTE_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(mute_r_q)) |-> out_right == '0); // R6
  AST_ZERO_RISE_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zero_left) |-> ($past(in_valid) && $past(in_left) == '0)); // R7
  AST_ZERO_CLEAR_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_left != '0) |=> !zero_left); // R8
  AST_ZERO_CLEAR_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_right != '0) |=> !zero_right); // R8
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(gain_q)); // R9
endmodule

bind vol_stage vol_stage_chk #(.CODE_W(CODE_W), .UNITY_CODE(UNITY_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .in_valid(in_valid),
  .in_left(in_left), .in_right(in_right), .out_valid(out_valid),
  .out_left(out_left), .out_right(out_right), .zero_left(zero_left),
  .zero_right(zero_right), .gain_q(gain_q), .mute_l_q(mute_l_q),
  .mute_r_q(mute_r_q)
);

// File: tb/vol_stage_bench.sv
`timescale 1ns/1ps
module vol_stage_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [6:0] gain_code = 7'd0;
  logic mute_left = 1'b0, mute_right = 1'b0;
  logic [1:0] zto_sel = 2'd0;
  logic in_valid = 1'b0;
  logic signed [19:0] in_left = '0, in_right = '0;
  logic out_valid, zero_left, zero_right;
  logic signed [19:0] out_left, out_right;

  int n_checks = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  vol_stage u_vol_stage (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .gain_code(gain_code),
    .mute_left(mute_left), .mute_right(mute_right), .zto_sel(zto_sel),
    .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
    .zero_left(zero_left), .zero_right(zero_right)
  );

  task automatic chk_eq(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ideal gain from the requirement, with the stated tolerance
  task automatic chk_gain(input string tag, input int act, input int x, input int code);
    real ideal, tol, diff;
    ideal = real'(x) * (10.0 ** ((12.0 - 0.75 * real'(code)) / 20.0));
    if (ideal > 524287.0) ideal = 524287.0;
    if (ideal < -524288.0) ideal = -524288.0;
    tol  = real'(x < 0 ? -x : x) / 8192.0 + 1.0;
    diff = real'(act) - ideal;
    if (diff < 0.0) diff = -diff;
    n_checks++;
    if (diff > tol) begin
      n_fail++;
      $display("FAIL %s code=%0d actual=%0d expected=%0.2f", tag, code, act, ideal);
    end
  endtask

  task automatic cfg(input int g, input logic ml, input logic mr, input int sel);
    @(negedge clk);
    gain_code = 7'(g); mute_left = ml; mute_right = mr; zto_sel = 2'(sel);
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // drives one sample; on return the registered result is on the outputs
  task automatic send(input int l, input int r);
    @(negedge clk);
    in_left = 20'(l); in_right = 20'(r); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk_eq("R1 out_valid in reset", int'(out_valid), 0);
    chk_eq("R1 out_left in reset", int'(out_left), 0);
    chk_eq("R1 zero flags in reset", int'({zero_left, zero_right}), 0);
    @(negedge clk); rst_n = 1'b1;
    send(12345, -6789);
    chk_eq("R1 default gain left", int'(out_left), 12345);
    chk_eq("R1 default gain right", int'(out_right), -6789);
  endtask

  task automatic t_unity;
    cfg(16, 1'b0, 1'b0, 0);
    send(524287, -524288);
    chk_eq("R2 unity max", int'(out_left), 524287);
    chk_eq("R2 unity min", int'(out_right), -524288);
    send(-1, 1);
    chk_eq("R2 unity -1", int'(out_left), -1);
    chk_eq("R2 unity +1", int'(out_right), 1);
  endtask

  task automatic t_gain;
    int codes[8] = '{0, 1, 8, 15, 17, 40, 80, 127};
    foreach (codes[i]) begin
      cfg(codes[i], 1'b0, 1'b0, 0);
      send(100000, -77777);
      chk_gain("R3 left", int'(out_left), 100000, codes[i]);
      chk_gain("R3 right", int'(out_right), -77777, codes[i]);
    end
  endtask

  task automatic t_sat;
    cfg(0, 1'b0, 1'b0, 0);
    send(500000, -500000);
    chk_eq("R4 clip high", int'(out_left), 524287);
    chk_eq("R4 clip low", int'(out_right), -524288);
    cfg(8, 1'b0, 1'b0, 0);
    send(-300000, 300000);
    chk_eq("R4 clip low 6dB", int'(out_left), -524288);
    chk_eq("R4 clip high 6dB", int'(out_right), 524287);
  endtask

  task automatic t_timing;
    cfg(16, 1'b0, 1'b0, 0);
    send(4242, -4242);
    chk_eq("R5 out_valid pulse", int'(out_valid), 1);
    @(negedge clk);
    chk_eq("R5 out_valid drops", int'(out_valid), 0);
    in_left = 20'(999);
    @(negedge clk);
    chk_eq("R5 hold without strobe", int'(out_left), 4242);
  endtask

  task automatic t_mute;
    cfg(16, 1'b1, 1'b0, 0);
    send(3000, 3000);
    chk_eq("R6 left muted", int'(out_left), 0);
    chk_eq("R6 right live", int'(out_right), 3000);
    cfg(16, 1'b0, 1'b1, 0);
    send(-3000, -3000);
    chk_eq("R6 left live", int'(out_left), -3000);
    chk_eq("R6 right muted", int'(out_right), 0);
    cfg(16, 1'b0, 1'b0, 0);
  endtask

  task automatic t_cfg_hold;
    cfg(16, 1'b0, 1'b0, 0);
    @(negedge clk);
    gain_code = 7'd0; mute_left = 1'b1; mute_right = 1'b1;
    send(1000, -1000);
    chk_eq("R9 pins ignored left", int'(out_left), 1000);
    chk_eq("R9 pins ignored right", int'(out_right), -1000);
    mute_left = 1'b0; mute_right = 1'b0;
  endtask

  task automatic run_zeros(input int n, input int rval);
    for (int k = 0; k < n; k++) send(0, rval);
  endtask

  task automatic t_zero;
    cfg(16, 1'b1, 1'b0, 0);   // mute must not affect detection
    send(5, 5);
    run_zeros(512, 7);
    chk_eq("R7 sel0 one short", int'(zero_left), 0);
    run_zeros(1, 7);
    chk_eq("R7 sel0 reached", int'(zero_left), 1);
    chk_eq("R7 right independent", int'(zero_right), 0);
    send(9, 0);
    chk_eq("R8 nonzero clears", int'(zero_left), 0);
    run_zeros(512, 7);
    chk_eq("R8 count restarted", int'(zero_left), 0);
    cfg(16, 1'b0, 1'b0, 1);
    send(1, 1);
    for (int k = 0; k < 1024; k++) send(7, 0);
    chk_eq("R7 sel1 one short", int'(zero_right), 0);
    send(7, 0);
    chk_eq("R7 sel1 reached", int'(zero_right), 1);
    cfg(16, 1'b0, 1'b0, 3);
    send(1, 1);
    run_zeros(4096, 1);
    chk_eq("R7 sel3 one short", int'(zero_left), 0);
    run_zeros(1, 1);
    chk_eq("R7 sel3 reached", int'(zero_left), 1);
  endtask

  initial begin
    #2;
    t_reset();
    t_unity();
    t_gain();
    t_sat();
    t_timing();
    t_mute();
    t_cfg_hold();
    t_zero();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1_500_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule